// File: doc/BRIEF.md
# Debug Suspend Router

This block decides, for every peripheral on a chip, whether that peripheral should pause while a debugger holds one or more processor cores halted. It takes a halt-status vector from up to 32 cores and drives up to 64 registered suspend outputs, one per peripheral.

Each peripheral output has its own 9-bit configuration word. The word chooses where the halt comes from: a single named core, every participating core at once (AND), or any participating core (OR). A shared 32-bit participation mask decides which cores count toward the AND and OR reductions. Two more bits in the word control how the output behaves. The release bit switches suspend off for that peripheral. The deferred bit makes the output wait until the peripheral reports that it has reached a safe completion point, instead of pausing at once.

Software or a debug agent programs the words through a small write/read port. Setting address bit 6 selects the participation mask. Clearing it selects the sink whose index is held in address bits 5:0. A read returns the stored contents combinationally.

Top module: `dsr_router`

## Requirements
- R1: After reset every sink word reads 0: mode 00, core index 0, deferred 0 and release 0. The participation mask reads all ones, and every suspend output is 0.
- R2: Mode 00 selects the AND of the participating cores. The source is 1 only when the mask is non-zero and every core with a mask bit of 1 is halted.
- R3: Cores whose mask bit is 0 are ignored by both reductions. An all-zero mask drives both the AND and the OR source to 0.
- R4: Mode 01 selects the OR of the participating cores. The source is 1 when any masked-in core is halted.
- R5: Mode 10 selects the single core named by the index field. Mode 11 behaves as mode 00.
- R6: When the release bit (word bit 8) is 1, that sink's suspend output is 0 in the cycle after, whatever the cores and completion inputs do.
- R7: When the deferred bit (word bit 7) is 0, the suspend output equals the selected source as it was one clock earlier.
- R8: When the deferred bit is 1, the output rises only at an edge where the selected source is 1 and that sink's completion input is 1. It then stays 1 while the source stays 1, and clears at the first edge after the source drops.
- R9: Writes take effect at the clock edge. The sink word layout is bits 1:0 mode, 6:2 core index, 7 deferred and 8 release. The read data returns the stored word (or mask) zero-extended, with no clock delay.
- R10: A configuration write changes the output one cycle later. A held deferred suspend is cancelled if the newly selected source is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_halt | input | NUM_CORES | Halt status per core |
| periph_done | input | NUM_SINKS | Completion-point flag per peripheral |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | log2(NUM_SINKS)+1 | Top bit selects the mask; the low bits select a sink |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| periph_suspend | output | NUM_SINKS | Registered suspend output per peripheral |

## Verification
The core vector is driven in three ways: all halted, all halted with a few holes, and fully random. All-halted against holed patterns separates the AND from the OR reduction. Patterns applied after mask writes (empty, partial and full) show whether the masked-out cores are truly ignored. Directed sequences on single sinks test single-core selection and deferred entry, hold and release, and cancellation after a reconfiguration. Random completion flags, mixed with random writes to the configuration words, then try every mode against a bench model.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic [1:0] {
        SRC_ALL_AND = 2'b00,
        SRC_ANY_OR  = 2'b01,
        SRC_SINGLE  = 2'b10,
        SRC_RSVD    = 2'b11
    } src_mode_e;

    // Word layout: [8] release, [7] deferred, [6:2] core index, [1:0] mode
    typedef struct packed {
        logic      release_en;
        logic      deferred;
        logic [4:0] core_idx;
        src_mode_e mode;
    } sink_cfg_t;

    localparam int unsigned CFG_W = $bits(sink_cfg_t);

endpackage

// File: rtl/dsr_cfg_regs.sv
module dsr_cfg_regs #(
    parameter int unsigned NUM_CORES = 32,
    parameter int unsigned NUM_SINKS = 64,
    parameter int unsigned SINK_AW   = 6
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [SINK_AW:0]                       addr,
    input  logic [31:0]                            wdata,
    output logic [31:0]                            rdata,
    output dsr_pkg::sink_cfg_t [NUM_SINKS-1:0]     sink_cfg_o,
    output logic [NUM_CORES-1:0]                   mask_o
);
    import dsr_pkg::*;

    typedef struct packed {
        logic [NUM_CORES-1:0]          mask;
        sink_cfg_t [NUM_SINKS-1:0]     cfg;
    } regs_t;

    regs_t st_d, st_q;
    logic  sel_mask;
    logic  sink_hit;

    assign sel_mask = addr[SINK_AW];
    assign sink_hit = (32'(addr[SINK_AW-1:0]) < NUM_SINKS);

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (sel_mask) begin
                st_d.mask = wdata[NUM_CORES-1:0];
            end else if (sink_hit) begin
                st_d.cfg[addr[SINK_AW-1:0]] = sink_cfg_t'(wdata[CFG_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.cfg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_mask) begin
            rdata[NUM_CORES-1:0] = st_q.mask;
        end else if (sink_hit) begin
            rdata[CFG_W-1:0] = st_q.cfg[addr[SINK_AW-1:0]];
        end
    end

    assign sink_cfg_o = st_q.cfg;
    assign mask_o     = st_q.mask;

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel_mask) |=> (mask_o == $past(wdata[NUM_CORES-1:0]))); // R9
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mask_o)); // R9

endmodule

// File: rtl/dsr_source_select.sv
module dsr_source_select #(
    parameter int unsigned NUM_CORES = 32,
    parameter int unsigned NUM_SINKS = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_CORES-1:0]                core_halt,
    input  logic [NUM_CORES-1:0]                mask,
    input  dsr_pkg::sink_cfg_t [NUM_SINKS-1:0]  sink_cfg,
    output logic [NUM_SINKS-1:0]                src_o
);
    import dsr_pkg::*;

    logic and_all;
    logic or_all;

    always_comb begin
        and_all = (mask != '0) && ((core_halt | ~mask) == '1);
        or_all  = |(core_halt & mask);
    end

    for (genvar s = 0; s < NUM_SINKS; s++) begin : g_sink
        logic single;
        always_comb begin
            single = (32'(sink_cfg[s].core_idx) < NUM_CORES) ?
                     core_halt[sink_cfg[s].core_idx] : 1'b0;
            unique case (sink_cfg[s].mode)
                SRC_ANY_OR:  src_o[s] = or_all;
                SRC_SINGLE:  src_o[s] = single;
                default:     src_o[s] = and_all;
            endcase
        end
    end

    AST_AND_IMPLIES_OR: assert property (@(posedge clk) disable iff (!rst_n)
        and_all |-> or_all); // R3
    AST_EMPTY_MASK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (!and_all && !or_all)); // R3

endmodule

// File: rtl/dsr_sink_gate.sv
module dsr_sink_gate (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_i,
    input  logic               done_i,
    input  dsr_pkg::sink_cfg_t cfg_i,
    output logic               susp_o
);
    typedef struct packed {
        logic susp;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_i.release_en || !src_i) begin
            st_d.susp = 1'b0;
        end else if (!cfg_i.deferred) begin
            st_d.susp = 1'b1;
        end else begin
            st_d.susp = st_q.susp | done_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign susp_o = st_q.susp;

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.release_en |=> !susp_o); // R6
    AST_IMM_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.release_en && !cfg_i.deferred) |=> (susp_o == $past(src_i))); // R7
    AST_DEF_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.deferred && !susp_o && !done_i) |=> !susp_o); // R8
    AST_DEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.release_en && cfg_i.deferred && susp_o && src_i) |=> susp_o); // R8
    AST_SRC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !src_i |=> !susp_o); // R10

endmodule

// File: rtl/dsr_router.sv
module dsr_router #(
    parameter int unsigned NUM_CORES = 32,
    parameter int unsigned NUM_SINKS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          core_halt,
    input  logic [NUM_SINKS-1:0]          periph_done,
    input  logic                          cfg_we,
    input  logic [$clog2(NUM_SINKS):0]    cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    output logic [31:0]                   cfg_rdata,
    output logic [NUM_SINKS-1:0]          periph_suspend
);
    import dsr_pkg::*;

    localparam int unsigned SINK_AW = $clog2(NUM_SINKS);

    sink_cfg_t [NUM_SINKS-1:0] sink_cfg;
    logic [NUM_CORES-1:0]      mask;
    logic [NUM_SINKS-1:0]      src;

    dsr_cfg_regs #(
        .NUM_CORES (NUM_CORES),
        .NUM_SINKS (NUM_SINKS),
        .SINK_AW   (SINK_AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .sink_cfg_o (sink_cfg),
        .mask_o     (mask)
    );

    dsr_source_select #(
        .NUM_CORES (NUM_CORES),
        .NUM_SINKS (NUM_SINKS)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_halt (core_halt),
        .mask      (mask),
        .sink_cfg  (sink_cfg),
        .src_o     (src)
    );

    for (genvar s = 0; s < NUM_SINKS; s++) begin : g_gate
        dsr_sink_gate u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src[s]),
            .done_i (periph_done[s]),
            .cfg_i  (sink_cfg[s]),
            .susp_o (periph_suspend[s])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (periph_suspend == '0 || rst_n)); // R1

endmodule

// File: tb/dsr_router_tb.sv
`timescale 1ns/1ps
module dsr_router_tb;
    localparam int NC = 32;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] core_halt = '0;
    logic [NS-1:0] periph_done = '0;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NS-1:0] periph_suspend;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done_flag = 1'b0;

    logic [8:0]    m_cfg [NS];
    logic [NC-1:0] m_mask;
    logic [NS-1:0] m_exp;

    always #2.5 clk = ~clk;

    dsr_router u_dut (
        .clk(clk), .rst_n(rst_n), .core_halt(core_halt), .periph_done(periph_done),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .periph_suspend(periph_suspend)
    );

    function automatic logic m_src(input int s, input logic [NC-1:0] c);
        logic a, o;
        a = (m_mask != '0) && ((c | ~m_mask) == '1);
        o = |(c & m_mask);
        case (m_cfg[s][1:0])
            2'b01:   return o;
            2'b10:   return c[m_cfg[s][6:2]];
            default: return a;
        endcase
    endfunction

    function automatic logic m_next(input int s, input logic [NC-1:0] c, input logic d, input logic q);
        logic src;
        src = m_src(s, c);
        if (m_cfg[s][8] || !src) return 1'b0;
        if (!m_cfg[s][7])        return 1'b1;
        return q | d;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [NC-1:0] c, input logic [NS-1:0] d,
                        input logic we, input logic [6:0] a, input logic [31:0] wd);
        logic [NS-1:0] nx;
        core_halt = c; periph_done = d; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        for (int s = 0; s < NS; s++) nx[s] = m_next(s, c, d[s], m_exp[s]);
        if (we) begin
            if (a[6]) m_mask = wd[NC-1:0];
            else      m_cfg[a[5:0]] = wd[8:0];
        end
        @(posedge clk);
        @(negedge clk);
        m_exp = nx;
        chk(tag, 64'(periph_suspend), 64'(m_exp));
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] wd);
        step("R9 write", core_halt, periph_done, 1'b1, a, wd);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [6:0] a, input logic [31:0] exp);
        cfg_we = 1'b0; cfg_addr = a;
        #0.5;
        chk(tag, 64'(cfg_rdata), 64'(exp));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [NC-1:0] c;
        void'($urandom(32'd20240611));
        for (int s = 0; s < NS; s++) m_cfg[s] = '0;
        m_mask = '1;
        m_exp  = '0;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", 64'(periph_suspend), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", 64'(periph_suspend), 64'd0);
        rd("R1 sink 0 word", 7'd0, 32'd0);
        rd("R1 sink 63 word", 7'd63, 32'd0);
        rd("R1 mask", 7'h40, 32'hFFFF_FFFF);

        // R2 AND-all default
        step("R2 all halted", '1, '0, 1'b0, '0, '0);
        chk("R2 all sinks suspended", 64'(periph_suspend), {64{1'b1}});
        step("R2 one core running", 32'hFFFF_FFFE, '0, 1'b0, '0, '0);
        chk("R2 AND drops", 64'(periph_suspend), 64'd0);

        // R4 OR-all on sink 1, R5 single core on sink 2 and reserved mode on sink 3
        wr(7'd1, 32'h001);
        wr(7'd2, {23'd0, 2'b00, 5'd7, 2'b10});
        wr(7'd3, 32'h003);
        rd("R9 read sink 2", 7'd2, 32'h01E);
        step("R4 one core halted", 32'h0000_0100, '0, 1'b0, '0, '0);
        chk("R4 OR sink up", 64'(periph_suspend[1]), 64'd1);
        chk("R5 single core 7 low", 64'(periph_suspend[2]), 64'd0);
        step("R5 core 7 halted", 32'h0000_0080, '0, 1'b0, '0, '0);
        chk("R5 single core sink up", 64'(periph_suspend[2]), 64'd1);
        chk("R5 reserved mode acts as AND", 64'(periph_suspend[3]), 64'd0);

        // R3 mask
        wr(7'h40, 32'h0000_00F0);
        rd("R9 read mask", 7'h40, 32'h0000_00F0);
        step("R3 masked-in all halted", 32'h0000_00F0, '0, 1'b0, '0, '0);
        chk("R3 AND of masked cores", 64'(periph_suspend[0]), 64'd1);
        step("R3 masked-out core ignored by OR", 32'h0000_0001, '0, 1'b0, '0, '0);
        chk("R3 OR ignores masked-out core", 64'(periph_suspend[1]), 64'd0);
        wr(7'h40, 32'h0);
        step("R3 empty mask", '1, '0, 1'b0, '0, '0);
        chk("R3 empty mask AND", 64'(periph_suspend[0]), 64'd0);
        chk("R3 empty mask OR", 64'(periph_suspend[1]), 64'd0);
        wr(7'h40, 32'hFFFF_FFFF);

        // R6 release bit
        wr(7'd4, 32'h100);
        step("R6 release", '1, '1, 1'b0, '0, '0);
        chk("R6 released sink stays low", 64'(periph_suspend[4]), 64'd0);
        chk("R7 immediate sink follows", 64'(periph_suspend[0]), 64'd1);

        // R8 deferred on sink 5 (OR-all)
        wr(7'd5, 32'h081);
        step("R8 idle", '0, '0, 1'b0, '0, '0);
        step("R8 source up no done", 32'h1, '0, 1'b0, '0, '0);
        chk("R8 waits for completion", 64'(periph_suspend[5]), 64'd0);
        step("R8 done", 32'h1, 64'(1) << 5, 1'b0, '0, '0);
        chk("R8 enters on completion", 64'(periph_suspend[5]), 64'd1);
        step("R8 hold", 32'h1, '0, 1'b0, '0, '0);
        chk("R8 holds", 64'(periph_suspend[5]), 64'd1);
        step("R8 source drops", '0, '0, 1'b0, '0, '0);
        chk("R8 clears after drop", 64'(periph_suspend[5]), 64'd0);

        // R10 reconfiguration cancels deferred suspend on sink 6
        wr(7'd6, 32'h081);
        step("R10 enter", '1, 64'(1) << 6, 1'b0, '0, '0);
        chk("R10 suspended", 64'(periph_suspend[6]), 64'd1);
        step("R10 rewrite", 32'hFFFF_FFF7, '0, 1'b1, 7'd6, {23'd0, 2'b10, 5'd3, 2'b10});
        chk("R10 old config still applied", 64'(periph_suspend[6]), 64'd1);
        step("R10 new source low", 32'hFFFF_FFF7, '0, 1'b0, '0, '0);
        chk("R10 cancelled", 64'(periph_suspend[6]), 64'd0);

        // random mix, R2 R4 R5 R7 R8 against the model
        for (int i = 0; i < 4000; i++) begin
            logic          we;
            logic [6:0]    a;
            logic [31:0]   wd;
            logic [NS-1:0] d;
            c  = ($urandom % 2) ? (32'hFFFF_FFFF & ~(32'h1 << ($urandom % 40))) : $urandom;
            d  = {$urandom, $urandom} & {$urandom, $urandom};
            we = ($urandom % 8) == 0;
            a  = {1'b0, 6'($urandom)};
            wd = $urandom & 32'h1FF;
            if (($urandom % 40) == 0) begin
                a  = 7'h40;
                wd = ($urandom % 3 == 0) ? 32'h0 : (($urandom % 2) ? 32'hFFFF_FFFF : $urandom);
            end
            step("R7 R8 random", c, d, we, a, wd);
        end

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule